// File: doc/BRIEF.md
# Free-Running System Timer with Compare Channels

The block is a system timer. A 64-bit counter advances by one on every tick of a built-in prescaler. With the default parameters the tick rate is 1 MHz. Software has no way to stop the counter or to load it.

Four 32-bit compare channels watch the low word of that counter. When the low word steps onto a channel's compare value, the channel sets a sticky match flag, and that flag drives the channel's own interrupt line. Software reads the flags from a status word at offset 0x00 and clears them by writing ones to the same word.

The counter is read as two words. A read of the low word (0x04) also captures the high word. A read of the high word (0x08) that follows therefore gives a coherent 64-bit value, even when a carry happens between the two reads.

Top module: `cmp_timer`

## Requirements
- R1: Reset sets the counter, every compare register and every match flag to zero, so that all `irq` lines are low.
- R2: The counter grows by exactly one every CLK_HZ/TICK_HZ clock cycles, and the low word carries into the high word.
- R3: A read of offset 0x04 returns the live low word and captures the high word in the same cycle. A read of offset 0x08 returns the captured high word.
- R4: A write to offset 0x04 or 0x08 has no effect on the counter.
- R5: Compare register n sits at offset 0x0C + 4*n. It is written and read back as a full 32-bit word.
- R6: Match flag n sets at the clock edge where the counter's low word advances to equal compare register n. A compare value that the count has already passed does not set the flag.
- R7: A match flag stays set after the count moves on and after its compare register is rewritten.
- R8: A write to offset 0x00 clears flag n for each data bit n that is 1. Flags whose data bit is 0 are unchanged.
- R9: `irq[n]` is the level of match flag n. A read of offset 0x00 returns the flags in bits NCH-1:0, with zeros above them.
- R10: Each channel sets and clears its flag independently of the other channels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (a low-word read captures the high word) |
| addr | input | AW | Byte offset of the access |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| irq | output | NCH | One level interrupt per compare channel |

## Verification
The assertions run on every cycle. They check four things:
- The counter moves only on a tick, and then by exactly one.
- A flag rises only when the new low word equals the compare value the channel held one cycle earlier.
- An interrupt falls only after a status write with a one in that channel's bit.
- The captured high word matches the counter's high word at the moment of the low-word read.

Only the bench scenarios can show the remaining behaviour:
- The exact tick spacing.
- That a compare value already passed stays silent.
- The stickiness of a flag across a compare rewrite.
- The coherence of the two-word read across a real carry, shown with an instance reset close to the low-word rollover.

// File: rtl/cmp_timer.sv
module cmp_timer #(
  parameter int          CLK_HZ   = 50_000_000,
  parameter int          TICK_HZ  = 1_000_000,
  parameter int          NCH      = 4,
  parameter int          AW       = 5,
  parameter logic [63:0] CNT_INIT = 64'd0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wr_data,
  output logic [31:0]   rd_data,
  output logic [NCH-1:0] irq
);
  localparam int DIV = (CLK_HZ / TICK_HZ < 1) ? 1 : CLK_HZ / TICK_HZ;
  localparam int PW  = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [AW-1:0] A_STAT = AW'(0);
  localparam logic [AW-1:0] A_LO   = AW'(4);
  localparam logic [AW-1:0] A_HI   = AW'(8);

  logic                   tick;
  logic [63:0]            cnt;
  logic [31:0]            hi_lat;
  logic [31:0]            next_lo;
  logic [NCH-1:0]         flg;
  logic [NCH-1:0][31:0]   cmp;

  generate
    if (DIV > 1) begin : g_pre
      logic [PW-1:0] pre;
      always_ff @(posedge clk) begin
        if (!rst_n)                pre <= '0;
        else if (pre == PW'(DIV-1)) pre <= '0;
        else                       pre <= pre + 1'b1;
      end
      assign tick = (pre == PW'(DIV-1));
    end else begin : g_nopre
      assign tick = 1'b1;
    end
  endgenerate

  assign next_lo = cnt[31:0] + 32'd1;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= CNT_INIT;
    else if (tick) cnt <= cnt + 64'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       hi_lat <= CNT_INIT[63:32];
    else if (rd_en && addr == A_LO)   hi_lat <= cnt[63:32];
  end

  wire clr_wr = wr_en && (addr == A_STAT);

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      wire sel = (addr == AW'(12 + 4*i));
      wire hit = tick && (next_lo == cmp[i]);
      always_ff @(posedge clk) begin
        if (!rst_n)              cmp[i] <= '0;
        else if (wr_en && sel)   cmp[i] <= wr_data;
      end
      always_ff @(posedge clk) begin
        if (!rst_n)                    flg[i] <= 1'b0;
        else if (hit)                  flg[i] <= 1'b1;
        else if (clr_wr && wr_data[i]) flg[i] <= 1'b0;
      end
    end
  endgenerate

  assign irq = flg;

  always_comb begin
    rd_data = '0;
    if (addr == A_STAT)    rd_data = 32'(flg);
    else if (addr == A_LO) rd_data = cnt[31:0];
    else if (addr == A_HI) rd_data = hi_lat;
    else begin
      for (int i = 0; i < NCH; i++)
        if (addr == AW'(12 + 4*i)) rd_data = cmp[i];
    end
  end
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk #(
  parameter int NCH = 4,
  parameter int AW  = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic                 rd_en,
  input logic [AW-1:0]        addr,
  input logic [31:0]          wr_data,
  input logic [NCH-1:0]       irq,
  input logic                 tick,
  input logic [63:0]          cnt,
  input logic [31:0]          hi_lat,
  input logic [NCH-1:0]       flg,
  input logic [NCH-1:0][31:0] cmp
);
  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tick && rst_n) |-> cnt == $past(cnt) + 64'd1);

  assert_count_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> $stable(cnt));

  assert_hi_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_en && addr == AW'(4)) |-> hi_lat == $past(cnt[63:32]));

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_a
      assert_flag_on_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flg[i]) |-> ($past(tick) && cnt[31:0] == $past(cmp[i])));

      assert_irq_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq[i]) |-> $past(wr_en && addr == AW'(0) && wr_data[i]));
    end
  endgenerate
endmodule

bind cmp_timer cmp_timer_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wr_data(wr_data), .irq(irq), .tick(tick), .cnt(cnt), .hi_lat(hi_lat),
  .flg(flg), .cmp(cmp)
);

// File: tb/cmp_timer_test.sv
module cmp_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIVR = 4;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic        rd_en = 0;
  logic [4:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data, rd_data_w;
  logic [3:0]  irq, irq_w;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_timer #(.CLK_HZ(4_000_000), .TICK_HZ(1_000_000)) uut (
    .clk, .rst_n, .wr_en, .rd_en, .addr, .wr_data, .rd_data, .irq);

  cmp_timer #(.CLK_HZ(4_000_000), .TICK_HZ(1_000_000),
              .CNT_INIT(64'h0000_0001_FFFF_F000)) uut_w (
    .clk, .rst_n, .wr_en, .rd_en, .addr, .wr_data, .rd_data(rd_data_w), .irq(irq_w));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // called at a negedge, returns at the next negedge
  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    addr = a; rd_en = 1; #1 v = rd_data;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(5'h04, v); chk(v == 0, "R1 low", v, 0);
    rd(5'h08, v); chk(v == 0, "R1 high", v, 0);
    rd(5'h00, v); chk(v == 0, "R1 status", v, 0);
    chk(irq == 0, "R1 irq", irq, 0);
    for (int n = 0; n < 4; n++) begin
      rd(5'(12 + 4*n), v); chk(v == 0, "R1 cmp", v, 0);
    end
  endtask

  task automatic t_wrap();
    logic [31:0] lo, hi;
    int bad = 0;
    bit seen = 0;
    for (int k = 0; k < 3000 && !seen; k++) begin
      addr = 5'h04; rd_en = 1; #1 lo = rd_data_w;
      @(negedge clk); rd_en = 0;
      repeat (6) @(negedge clk);
      addr = 5'h08; #1 hi = rd_data_w;
      @(negedge clk);
      if (hi != ((lo >= 32'hFFFF_0000) ? 32'd1 : 32'd2)) bad++;
      if (hi == 2) seen = 1;
    end
    chk(bad == 0, "R3 coherent pair", bad, 0);
    chk(seen, "R2 carry into high", seen, 1);
  endtask

  task automatic t_count();
    logic [31:0] a, b;
    rd(5'h04, a);
    repeat (39) @(negedge clk);
    rd(5'h04, b);
    chk(b - a == 10, "R2 tick rate", b - a, 10);
  endtask

  task automatic t_cmp_rw();
    logic [31:0] v, h;
    for (int n = 0; n < 4; n++) wr(5'(12 + 4*n), 32'hA5C0_0000 + 32'(n * 32'h1111));
    for (int n = 0; n < 4; n++) begin
      rd(5'(12 + 4*n), v);
      chk(v == 32'hA5C0_0000 + 32'(n * 32'h1111), "R5 cmp readback", v,
          32'hA5C0_0000 + 32'(n * 32'h1111));
    end
    rd(5'h04, v);
    wr(5'h04, 32'hDEAD_BEEF);
    wr(5'h08, 32'h5);
    rd(5'h04, h);
    chk(h - v <= 2, "R4 low not written", h, v);
    rd(5'h08, h);
    chk(h == 0, "R4 high not written", h, 0);
  endtask

  task automatic t_match();
    logic [31:0] v, lo, tgt;
    int bad = 0;
    rd(5'h04, v);
    tgt = v + 8;
    wr(5'h14, tgt);
    addr = 5'h04;
    for (int k = 0; k < 50; k++) begin
      #1 lo = rd_data;
      if (irq[2] != (lo >= tgt) || irq[1:0] != 0 || irq[3] != 0) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R6 flag at exact match", bad, 0);
    chk(irq == 4'b0100, "R9 irq level", irq, 4'b0100);
    rd(5'h00, v); chk(v == 32'h4, "R9 status word", v, 4);
    wr(5'h14, 32'h1234);
    repeat (8) @(negedge clk);
    chk(irq[2] == 1, "R7 sticky", irq, 4'b0100);
    wr(5'h00, 32'hFFFF_FFFB);
    #1 chk(irq[2] == 1, "R8 other bits keep flag", irq, 4'b0100);
    wr(5'h00, 32'h4);
    #1 chk(irq == 0, "R8 clear", irq, 0);
  endtask

  task automatic t_passed();
    logic [31:0] v;
    rd(5'h04, v);
    wr(5'h10, v - 1);
    repeat (20) @(negedge clk);
    chk(irq == 0, "R6 passed value silent", irq, 0);
  endtask

  task automatic t_two();
    logic [31:0] v;
    rd(5'h04, v);
    wr(5'h0C, v + 4);
    wr(5'h18, v + 9);
    repeat (50) @(negedge clk);
    rd(5'h00, v);
    chk(v == 32'h9, "R10 two channels", v, 9);
    wr(5'h00, 32'h8);
    #1 chk(irq == 4'b0001, "R10 independent clear", irq, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_count();
    t_cmp_rw();
    t_match();
    t_passed();
    t_two();
    t_wrap();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150_000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule